// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block is the digital feedback divider of a frequency synthesizer loop. A fast input clock runs through a dual-modulus prescaler model. The prescaler divides by M+1 or by M, and the modulus control signal picks which. A swallow counter holds that control high for the first A prescaler periods of each division cycle. A main counter ends the cycle after N prescaler periods. One full cycle therefore lasts M×N + A input clocks, and the block emits one comparison pulse per cycle for the phase detector. The base modulus M is 64 or 128, chosen per setting.

New settings arrive as a modulus-select bit, a 7-bit swallow value and an 11-bit main count, captured on a load strobe. A setting is checked when it is captured. If it is legal it waits in a pending slot and is applied only at the next cycle boundary. If it is illegal it is dropped, an error flag is raised, and the divider keeps running on what it had.

The sequencer has three states:
- IDLE: after reset, before any legal setting.
- SWALLOW: the prescaler divides by M+1.
- PLAIN: the prescaler divides by M.

It has four transitions:
- IDLE→start: a setting is pending.
- SWALLOW→PLAIN: the swallow count runs out.
- cycle restart: the last main period ends, and the state goes back to SWALLOW, or to PLAIN when A=0.
- The state stays put on a prescaler tick that ends neither the swallow phase nor the cycle.

Top module: `psd_divider`

## Requirements
- R1: After reset `cmp_pulse`, `mod_ctrl` and `cfg_err` are low, and no pulse appears until a legal setting has been captured.
- R2: The base modulus M is 64 when `mod_sel` is 1 and 128 when `mod_sel` is 0.
- R3: Consecutive comparison pulses are exactly M×N + A input clocks apart while one setting is in force.
- R4: `mod_ctrl` is high for the first A×(M+1) clocks of each cycle and low for the rest. With A=0 it never rises.
- R5: `cmp_pulse` is high for one clock, on the last clock of each cycle, and `mod_ctrl` is low in that clock.
- R6: A legal setting captured mid-cycle leaves the current cycle's length unchanged and governs from the next cycle on.
- R7: A setting with N<3 or A≥N sets `cfg_err` on the edge that captures it, and the divider output is unaffected. A legal capture clears `cfg_err`. Without a strobe the flag holds.
- R8: From IDLE, the first division cycle starts on the second rising edge after the strobe's capture edge. The first pulse is therefore seen T+1 edges after the capture edge, where T = M×N + A.
- R9: When two legal settings are captured within one cycle, the later one is the one applied at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock (the clock being divided) |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Strobe that captures a new setting |
| mod_sel | input | 1 | Base modulus select: 1 gives 64, 0 gives 128 |
| swallow_in | input | 7 | Swallow count A (0..127) |
| main_in | input | 11 | Main count N (3..2047) |
| cmp_pulse | output | 1 | One-clock comparison pulse, once per division cycle |
| mod_ctrl | output | 1 | Modulus control: high while the prescaler divides by M+1 |
| cfg_err | output | 1 | Last captured setting was illegal |

## Verification
The assertions assume that the strobe inputs are stable around the rising edge. They also assume the shortest possible cycle, 3×64 clocks, is longer than two clocks, which the legality check guarantees for any setting in force. The swallow-entry check further assumes that, once running, the divider never stops, so every rise of the modulus control after the first cycle follows a pulse. The stimulus changes inputs only on falling edges. It uses small N and A values so that cycles stay short. It puts illegal and back-to-back settings at points inside a cycle chosen so that the pending-slot and boundary rules decide the result.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_PLAIN   = 2'd2
    } psd_state_e;

endpackage

// File: rtl/psd_cfg_gate.sv
module psd_cfg_gate #(
    parameter int SW_W = 7,
    parameter int MN_W = 11,
    parameter int MIN_MAIN = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            mod_sel,
    input  logic [SW_W-1:0] swallow_in,
    input  logic [MN_W-1:0] main_in,
    input  logic            consume,
    output logic            pend_valid,
    output logic [SW_W-1:0] pend_a,
    output logic [MN_W-1:0] pend_n,
    output logic            pend_big,
    output logic            cfg_err
);

    localparam int PAD_W = MN_W - SW_W;
    localparam logic [MN_W-1:0] N_FLOOR = MN_W'(MIN_MAIN);

    logic legal_c;

    always_comb begin
        legal_c = (main_in >= N_FLOOR) && ({{PAD_W{1'b0}}, swallow_in} < main_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_a     <= '0;
            pend_n     <= '0;
            pend_big   <= 1'b0;
            cfg_err    <= 1'b0;
        end else begin
            if (load && legal_c) begin
                pend_valid <= 1'b1;
                pend_a     <= swallow_in;
                pend_n     <= main_in;
                pend_big   <= ~mod_sel;
                cfg_err    <= 1'b0;
            end else begin
                if (load) begin
                    cfg_err <= 1'b1;
                end
                if (consume) begin
                    pend_valid <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int SMALL_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic reload,
    input  logic big_mod,
    input  logic wide,
    output logic tick
);

    localparam int CNT_W = SMALL_LOG2 + 2;
    localparam logic [CNT_W-1:0] SMALL_M = CNT_W'(1 << SMALL_LOG2);
    localparam logic [CNT_W-1:0] BIG_M   = CNT_W'(1 << (SMALL_LOG2 + 1));
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base_c;
    logic [CNT_W-1:0] start_val_c;

    always_comb begin
        base_c      = big_mod ? BIG_M : SMALL_M;
        start_val_c = wide ? base_c : (base_c - ONE);
        tick        = run && (cnt_q == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= start_val_c;
        end else if (run) begin
            cnt_q <= cnt_q - ONE;
        end
    end

endmodule

// File: rtl/psd_seq.sv
module psd_seq
    import psd_pkg::*;
#(
    parameter int SW_W = 7,
    parameter int MN_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            pend_valid,
    input  logic [SW_W-1:0] pend_a,
    input  logic [MN_W-1:0] pend_n,
    input  logic            pend_big,
    output logic            run,
    output logic            reload,
    output logic            big_now,
    output logic            wide_next,
    output logic            consume,
    output logic            cmp_pulse,
    output logic            mod_ctrl
);

    localparam logic [MN_W-1:0] N_ONE = MN_W'(1);
    localparam logic [SW_W-1:0] A_ONE = SW_W'(1);

    psd_state_e      st_q, st_d;
    logic [SW_W-1:0] a_q, a_d;
    logic [MN_W-1:0] n_q, n_d;
    logic [SW_W-1:0] act_a_q;
    logic [MN_W-1:0] act_n_q;
    logic            act_big_q;

    logic            last_c, start_c;
    logic [SW_W-1:0] use_a;
    logic [MN_W-1:0] use_n;
    logic            use_big;

    // next-state logic
    always_comb begin
        last_c  = (st_q != ST_IDLE) && tick && (n_q == N_ONE);
        start_c = ((st_q == ST_IDLE) && pend_valid) || last_c;
        use_a   = pend_valid ? pend_a   : act_a_q;
        use_n   = pend_valid ? pend_n   : act_n_q;
        use_big = pend_valid ? pend_big : act_big_q;
        st_d = st_q;
        a_d  = a_q;
        n_d  = n_q;
        if (start_c) begin
            st_d = (use_a != '0) ? ST_SWALLOW : ST_PLAIN;
            a_d  = use_a;
            n_d  = use_n;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d = ST_IDLE;
                end
                ST_SWALLOW: begin
                    if (tick) begin
                        n_d = n_q - N_ONE;
                        a_d = a_q - A_ONE;
                        if (a_q == A_ONE) begin
                            st_d = ST_PLAIN;
                        end
                    end
                end
                ST_PLAIN: begin
                    if (tick) begin
                        n_d = n_q - N_ONE;
                    end
                end
                default: begin
                    st_d = ST_IDLE;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            a_q       <= '0;
            n_q       <= '0;
            act_a_q   <= '0;
            act_n_q   <= '0;
            act_big_q <= 1'b0;
        end else begin
            st_q <= st_d;
            a_q  <= a_d;
            n_q  <= n_d;
            if (start_c) begin
                act_a_q   <= use_a;
                act_n_q   <= use_n;
                act_big_q <= use_big;
            end
        end
    end

    // outputs
    always_comb begin
        run       = (st_q != ST_IDLE);
        reload    = start_c || tick;
        big_now   = start_c ? use_big : act_big_q;
        wide_next = (st_d == ST_SWALLOW);
        consume   = start_c && pend_valid;
        cmp_pulse = last_c;
        mod_ctrl  = (st_q == ST_SWALLOW);
    end

endmodule

// File: rtl/psd_divider.sv
module psd_divider #(
    parameter int SW_W       = 7,
    parameter int MN_W       = 11,
    parameter int SMALL_LOG2 = 6,
    parameter int MIN_MAIN   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            mod_sel,
    input  logic [SW_W-1:0] swallow_in,
    input  logic [MN_W-1:0] main_in,
    output logic            cmp_pulse,
    output logic            mod_ctrl,
    output logic            cfg_err
);

    logic            pend_valid;
    logic [SW_W-1:0] pend_a;
    logic [MN_W-1:0] pend_n;
    logic            pend_big;
    logic            consume;
    logic            run, reload, big_now, wide_next, tick;

    psd_cfg_gate #(.SW_W(SW_W), .MN_W(MN_W), .MIN_MAIN(MIN_MAIN)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .mod_sel    (mod_sel),
        .swallow_in (swallow_in),
        .main_in    (main_in),
        .consume    (consume),
        .pend_valid (pend_valid),
        .pend_a     (pend_a),
        .pend_n     (pend_n),
        .pend_big   (pend_big),
        .cfg_err    (cfg_err)
    );

    psd_seq #(.SW_W(SW_W), .MN_W(MN_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .pend_valid (pend_valid),
        .pend_a     (pend_a),
        .pend_n     (pend_n),
        .pend_big   (pend_big),
        .run        (run),
        .reload     (reload),
        .big_now    (big_now),
        .wide_next  (wide_next),
        .consume    (consume),
        .cmp_pulse  (cmp_pulse),
        .mod_ctrl   (mod_ctrl)
    );

    psd_prescaler #(.SMALL_LOG2(SMALL_LOG2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .reload  (reload),
        .big_mod (big_now),
        .wide    (wide_next),
        .tick    (tick)
    );

endmodule

// File: rtl/psd_divider_chk.sv
module psd_divider_chk #(
    parameter int SW_W     = 7,
    parameter int MN_W     = 11,
    parameter int MIN_MAIN = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            load,
    input logic [SW_W-1:0] swallow_in,
    input logic [MN_W-1:0] main_in,
    input logic            cmp_pulse,
    input logic            mod_ctrl,
    input logic            cfg_err
);

    localparam int PAD_W = MN_W - SW_W;

    logic legal_in;
    logic armed_q;
    logic seen_pulse_q;

    always_comb begin
        legal_in = (main_in >= MN_W'(MIN_MAIN)) && ({{PAD_W{1'b0}}, swallow_in} < main_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q      <= 1'b0;
            seen_pulse_q <= 1'b0;
        end else begin
            if (load && legal_in) armed_q <= 1'b1;
            if (cmp_pulse) seen_pulse_q <= 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> !cmp_pulse);

    assert_swallow_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mod_ctrl) && seen_pulse_q) |-> $past(cmp_pulse));

    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pulse |=> !cmp_pulse);

    assert_pulse_plain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_pulse |-> !mod_ctrl);

    assert_reject_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !legal_in) |=> cfg_err);

    assert_accept_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && legal_in) |=> !cfg_err);

    assert_err_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_err));

endmodule

bind psd_divider psd_divider_chk #(.SW_W(SW_W), .MN_W(MN_W), .MIN_MAIN(MIN_MAIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .swallow_in (swallow_in),
    .main_in    (main_in),
    .cmp_pulse  (cmp_pulse),
    .mod_ctrl   (mod_ctrl),
    .cfg_err    (cfg_err)
);

// File: tb/psd_divider_tb.sv
`timescale 1ns/1ps
module psd_divider_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic        mod_sel = 1'b0;
    logic [6:0]  swallow_in = '0;
    logic [10:0] main_in = '0;
    logic        cmp_pulse, mod_ctrl, cfg_err;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;

    psd_divider u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .mod_sel(mod_sel),
        .swallow_in(swallow_in), .main_in(main_in),
        .cmp_pulse(cmp_pulse), .mod_ctrl(mod_ctrl), .cfg_err(cfg_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // behavioural reference: elapsed clocks in the current cycle
    bit m_run, m_pend, m_err;
    int m_el, m_T, m_A, m_M, m_N;
    int p_A, p_N, p_M;

    function automatic bit exp_pulse();
        return m_run && (m_el == m_T - 1);
    endfunction
    function automatic bit exp_mod();
        return m_run && (m_el < m_A * (m_M + 1));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pend = 0; m_err = 0; m_el = 0; m_T = 1;
            m_A = 0; m_M = 64; m_N = 3;
        end else begin
            if ((!m_run && m_pend) || (m_run && m_el == m_T - 1)) begin
                if (m_pend) begin
                    m_A = p_A; m_N = p_N; m_M = p_M; m_pend = 0;
                end
                m_run = 1; m_el = 0; m_T = m_M * m_N + m_A;
            end else if (m_run) begin
                m_el++;
            end
            if (load) begin
                if (int'(main_in) >= 3 && int'(swallow_in) < int'(main_in)) begin
                    m_pend = 1; p_A = swallow_in; p_N = main_in;
                    p_M = mod_sel ? 64 : 128; m_err = 0;
                end else begin
                    m_err = 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cmp_pulse == exp_pulse(), "R3/R5 cmp_pulse", cmp_pulse, exp_pulse());
            chk(mod_ctrl == exp_mod(), "R4 mod_ctrl", mod_ctrl, exp_mod());
            chk(cfg_err == m_err, "R7 cfg_err", cfg_err, m_err);
        end
    end

    task automatic put_cfg(input bit sel, input int a, input int n);
        mod_sel = sel; swallow_in = 7'(a); main_in = 11'(n); load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_pulse(output int t);
        forever begin
            @(negedge clk);
            if (cmp_pulse) break;
        end
        t = cyc;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, t3, base;
        bit saw_mod;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and quiet idle
        chk(cmp_pulse == 0, "R1 pulse after reset", cmp_pulse, 0);
        chk(mod_ctrl == 0, "R1 mod_ctrl after reset", mod_ctrl, 0);
        chk(cfg_err == 0, "R1 cfg_err after reset", cfg_err, 0);
        saw_mod = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (cmp_pulse || mod_ctrl) saw_mod = 1;
        end
        chk(saw_mod == 0, "R1 idle without setting", saw_mod, 0);

        // R8: first-pulse latency, M=64 N=5 A=2 -> T=322
        base = cyc;
        put_cfg(1'b1, 2, 5);
        wait_pulse(t0);
        chk(t0 - base == 323, "R8 first pulse latency", t0 - base, 323);
        wait_pulse(t1);
        chk(t1 - t0 == 322, "R3 period 64*5+2", t1 - t0, 322);

        // R6: new legal setting mid-cycle (M=64 N=4 A=1 -> 257)
        repeat (50) @(negedge clk);
        put_cfg(1'b1, 1, 4);
        wait_pulse(t2);
        chk(t2 - t1 == 322, "R6 running cycle unchanged", t2 - t1, 322);
        wait_pulse(t3);
        chk(t3 - t2 == 257, "R6 new setting at boundary", t3 - t2, 257);

        // R2: mod_sel=0 selects 128 (N=4 A=3 -> 515)
        put_cfg(1'b0, 3, 4);
        wait_pulse(t0);
        wait_pulse(t1);
        chk(t1 - t0 == 515, "R2 modulus 128 period", t1 - t0, 515);

        // R4: A=0, M=64 N=3 -> 192, mod_ctrl never high
        put_cfg(1'b1, 0, 3);
        wait_pulse(t0);
        saw_mod = 0;
        t2 = t0;
        while (t2 - t0 < 192) begin
            @(negedge clk);
            t2 = cyc;
            if (mod_ctrl) saw_mod = 1;
        end
        chk(saw_mod == 0, "R4 A=0 keeps mod_ctrl low", saw_mod, 0);
        chk(cmp_pulse == 1, "R3 period 64*3+0", cmp_pulse, 1);

        // R7: illegal settings rejected, output unchanged
        repeat (20) @(negedge clk);
        put_cfg(1'b0, 0, 2);
        chk(cfg_err == 1, "R7 N<3 flagged", cfg_err, 1);
        put_cfg(1'b1, 3, 3);
        chk(cfg_err == 1, "R7 A>=N flagged", cfg_err, 1);
        wait_pulse(t0);
        wait_pulse(t1);
        chk(t1 - t0 == 192, "R7 rejected setting ignored", t1 - t0, 192);
        put_cfg(1'b1, 0, 3);
        chk(cfg_err == 0, "R7 legal load clears flag", cfg_err, 0);

        // R9: two legal loads in one cycle, later wins (M=64 N=6 A=2 -> 386)
        wait_pulse(t0);
        repeat (30) @(negedge clk);
        put_cfg(1'b1, 1, 3);
        put_cfg(1'b1, 2, 6);
        wait_pulse(t1);
        chk(t1 - t0 == 192, "R9 current cycle kept", t1 - t0, 192);
        wait_pulse(t2);
        chk(t2 - t1 == 386, "R9 later setting applied", t2 - t1, 386);

        repeat (5) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule